// File: doc/BRIEF.md
# Flash Status Bit Generator

This block forms the status byte that a parallel NOR flash returns on its data bus when the host reads it while an embedded program or erase is running. It takes the operation state (programming, erasing, chip-wide erase, the sector-erase command window, suspended erase, time limit exceeded), the data being programmed, the read address, a mask of the sectors chosen for erase and a mask of the sectors whose erase failed. From these it produces the polling bit, two toggle bits, the timeout bit and the erase-window bit. The embedded algorithm, the array and the analog side sit outside this block.

Two toggle bits run independently. The busy toggle (bit 6) flips on every read strobe while an operation is active. The sector toggle (bit 2) flips only when the address being read lies in a sector that is being erased, is suspended in erase, or failed to erase. When the output should be array data rather than status, the block raises `arrayPass` and drives the status byte to zero, so that the surrounding read path can select the array. The sector map is the eleven-sector boot layout. A parameter picks whether the small sectors sit at the bottom or at the top of the space.

Top module: `fsb_status_gen`

## Requirements
- R1: After reset, with no operation active, `arrayPass` is 1 and `statusByte` is 0x00. Both toggle bits start at 0.
- R2: While `opProgram` is 1, bit 7 of `statusByte` is the inverse of `progData[7]`. Bit 3 reads 0.
- R3: While an erase is running or the erase command window is open (`opErase` or `inTimeout`, no program, not suspended), bit 7 reads 0.
- R4: While a program or erase (including the command window) is active, bit 6 flips after every cycle in which `rdStrobe` is 1. When the output is array data, bit 6 does not advance, and a later busy read shows the held value.
- R5: An `opStart` pulse clears both toggle bits to 0. This takes priority over a read strobe in the same cycle.
- R6: During a program or erase, bit 5 equals `timeLimit`, and bit 6 keeps toggling while it is set.
- R7: During erase, bit 3 reads 0 while `inTimeout` is 1 and reads 1 once the erase is running (`inTimeout` 0).
- R8: During erase with `timeLimit` at 0, bit 2 flips on a read only when the address's sector bit in `eraseSel` is set. When `chipErase` is 1, it flips on every read.
- R9: During erase with `timeLimit` at 1, bit 2 flips only on reads whose sector bit in `failSel` is set.
- R10: With `eraseSuspended` at 1 and no program running, a read of a sector selected in `eraseSel` returns bit 7 = 1, bit 6 held, bit 2 toggling, and `arrayPass` = 0. A read of any other sector gives `arrayPass` = 1 and status 0x00.
- R11: While programming during a suspended erase, bit 6 toggles on every read and bit 2 toggles only on reads of sectors selected in `eraseSel`.
- R12: In bottom-boot layout (byte address), the sectors are: 0 for 0x00000–0x03FFF, 1 for 0x04000–0x05FFF, 2 for 0x06000–0x07FFF, 3 for 0x08000–0x0FFFF, and 3+address[18:16] at and above 0x10000. Bit n of `eraseSel` and `failSel` names sector n.
- R13: The status byte layout is {bit7 polling, bit6 busy toggle, bit5 timeout, bit4 0, bit3 erase started, bit2 sector toggle, bit1 0, bit0 0}. Bits 4, 1 and 0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opStart | input | 1 | One-cycle pulse when a new operation begins |
| opProgram | input | 1 | Embedded program active |
| opErase | input | 1 | Embedded erase running |
| chipErase | input | 1 | Current erase covers the whole chip |
| inTimeout | input | 1 | Sector-erase command window open |
| eraseSuspended | input | 1 | Erase is suspended |
| timeLimit | input | 1 | Operation exceeded its time limit |
| progData | input | 8 | Data being programmed |
| rdAddr | input | 19 | Byte read address |
| eraseSel | input | 11 | Sectors chosen for erase |
| failSel | input | 11 | Sectors whose erase failed |
| rdStrobe | input | 1 | One-cycle read pulse |
| statusByte | output | 8 | Status returned for this read |
| arrayPass | output | 1 | Read should return array data |

## Verification
The bench walks the sector boundaries around sector 2 from both sides. A decoder off by one boundary would toggle bit 2 on the wrong side of 0x06000 or 0x08000. It checks that bit 6 holds across array reads and clears on `opStart`. A toggle running freely, or one not cleared, would show the wrong phase on the next busy read. It also covers suspended reads of erasing and non-erasing sectors, and erase reads with the time limit set. A design that mixed up the erase and fail masks, or toggled bit 6 in suspend, would show the wrong bit 2, bit 6 or `arrayPass`.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam int ADDR_W   = 19;
  localparam int NUM_SECT = 11;
  localparam int SECT_W   = $clog2(NUM_SECT);

  typedef enum logic [1:0] {
    MODE_ARRAY   = 2'd0,
    MODE_PROG    = 2'd1,
    MODE_ERASE   = 2'd2,
    MODE_SUSPHIT = 2'd3
  } fsbMode_t;

  typedef struct packed {
    fsbMode_t mode;
    logic     clr;
    logic     flip6;
    logic     flip2;
    logic     eraseRun;
  } fsbStrobes_t;
endpackage

// File: rtl/fsb_sector_decode.sv
module fsb_sector_decode
  import fsb_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SECT_W-1:0] sector
);
  logic [ADDR_W-1:0] mapped;
  logic [SECT_W-1:0] lowIdx;

  generate
    if (TOP_BOOT) begin : g_top
      assign mapped = ~addr;
      assign sector = SECT_W'(NUM_SECT - 1) - lowIdx;
    end else begin : g_bottom
      assign mapped = addr;
      assign sector = lowIdx;
    end
  endgenerate

  always_comb begin
    if (mapped[18:16] != 3'd0)   lowIdx = SECT_W'(3) + SECT_W'(mapped[18:16]);
    else if (mapped[15])         lowIdx = SECT_W'(3);
    else if (!mapped[14])        lowIdx = SECT_W'(0);
    else if (!mapped[13])        lowIdx = SECT_W'(1);
    else                         lowIdx = SECT_W'(2);
  end
endmodule

// File: rtl/fsb_ctrl.sv
module fsb_ctrl
  import fsb_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic                opStart,
  input  logic                opProgram,
  input  logic                opErase,
  input  logic                chipErase,
  input  logic                inTimeout,
  input  logic                eraseSuspended,
  input  logic                timeLimit,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [NUM_SECT-1:0] eraseSel,
  input  logic [NUM_SECT-1:0] failSel,
  input  logic                rdStrobe,
  output fsbStrobes_t         str
);
  logic [SECT_W-1:0] sector;
  logic selHit, failHit, act6, act2;
  fsbMode_t mode;

  fsb_sector_decode #(.TOP_BOOT(TOP_BOOT)) i_decode (
    .addr   (rdAddr),
    .sector (sector)
  );

  assign selHit  = eraseSel[sector];
  assign failHit = failSel[sector];

  always_comb begin
    if (opProgram)                 mode = MODE_PROG;
    else if (eraseSuspended)       mode = selHit ? MODE_SUSPHIT : MODE_ARRAY;
    else if (opErase || inTimeout) mode = MODE_ERASE;
    else                           mode = MODE_ARRAY;
  end

  always_comb begin
    act6 = 1'b0;
    act2 = 1'b0;
    unique case (mode)
      MODE_PROG: begin
        act6 = 1'b1;
        act2 = eraseSuspended && selHit;
      end
      MODE_ERASE: begin
        act6 = 1'b1;
        act2 = timeLimit ? failHit : (chipErase || selHit);
      end
      MODE_SUSPHIT: act2 = 1'b1;
      default: ;
    endcase
  end

  assign str.mode     = mode;
  assign str.clr      = opStart;
  assign str.flip6    = rdStrobe && act6;
  assign str.flip2    = rdStrobe && act2;
  assign str.eraseRun = !inTimeout;
endmodule

// File: rtl/fsb_datapath.sv
module fsb_datapath
  import fsb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  fsbStrobes_t str,
  input  logic        timeLimit,
  input  logic [7:0]  progData,
  output logic [7:0]  statusByte,
  output logic        arrayPass
);
  logic dq6Q, dq2Q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq6Q <= 1'b0;
      dq2Q <= 1'b0;
    end else if (str.clr) begin
      dq6Q <= 1'b0;
      dq2Q <= 1'b0;
    end else begin
      if (str.flip6) dq6Q <= !dq6Q;
      if (str.flip2) dq2Q <= !dq2Q;
    end
  end

  always_comb begin
    statusByte = 8'h00;
    arrayPass  = 1'b0;
    unique case (str.mode)
      MODE_PROG:    statusByte = {!progData[7], dq6Q, timeLimit, 1'b0, 1'b0, dq2Q, 2'b00};
      MODE_ERASE:   statusByte = {1'b0, dq6Q, timeLimit, 1'b0, str.eraseRun, dq2Q, 2'b00};
      MODE_SUSPHIT: statusByte = {1'b1, dq6Q, 1'b0, 1'b0, 1'b0, dq2Q, 2'b00};
      default:      arrayPass  = 1'b1;
    endcase
  end

  // R5: a start pulse leaves both toggles low
  a_r5_clear_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    str.clr |=> (!dq6Q && !dq2Q));
  // R4: busy toggle inverts after a counted read
  a_r4_busy_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (str.flip6 && !str.clr) |=> (dq6Q != $past(dq6Q)));
  // R4: no read, no movement
  a_r4_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!str.flip6 && !str.clr) |=> $stable(dq6Q));
endmodule

// File: rtl/fsb_status_gen.sv
module fsb_status_gen
  import fsb_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                opStart,
  input  logic                opProgram,
  input  logic                opErase,
  input  logic                chipErase,
  input  logic                inTimeout,
  input  logic                eraseSuspended,
  input  logic                timeLimit,
  input  logic [7:0]          progData,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [NUM_SECT-1:0] eraseSel,
  input  logic [NUM_SECT-1:0] failSel,
  input  logic                rdStrobe,
  output logic [7:0]          statusByte,
  output logic                arrayPass
);
  fsbStrobes_t str;

  fsb_ctrl #(.TOP_BOOT(TOP_BOOT)) i_ctrl (
    .opStart        (opStart),
    .opProgram      (opProgram),
    .opErase        (opErase),
    .chipErase      (chipErase),
    .inTimeout      (inTimeout),
    .eraseSuspended (eraseSuspended),
    .timeLimit      (timeLimit),
    .rdAddr         (rdAddr),
    .eraseSel       (eraseSel),
    .failSel        (failSel),
    .rdStrobe       (rdStrobe),
    .str            (str)
  );

  fsb_datapath i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .str        (str),
    .timeLimit  (timeLimit),
    .progData   (progData),
    .statusByte (statusByte),
    .arrayPass  (arrayPass)
  );

  a_r2_poll_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    opProgram |-> (statusByte[7] != progData[7]));
  a_r3_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!opProgram && !eraseSuspended && (opErase || inTimeout)) |-> !statusByte[7]);
  a_r7_window_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!opProgram && !eraseSuspended && inTimeout) |-> !statusByte[3]);
  a_r10_array_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    arrayPass |-> (statusByte == 8'h00));
  a_r13_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(statusByte & 8'h13) == 0);
endmodule

// File: tb/test_fsb_status_gen.sv
module test_fsb_status_gen;
  import fsb_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic opStart = 0, opProgram = 0, opErase = 0, chipErase = 0, inTimeout = 0;
  logic eraseSuspended = 0, timeLimit = 0, rdStrobe = 0;
  logic [7:0] progData = 8'h00;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [NUM_SECT-1:0] eraseSel = '0, failSel = '0;
  logic [7:0] statusByte;
  logic arrayPass;

  fsb_status_gen i_fsb_status_gen (.*);

  always #5 clk = ~clk;

  typedef struct { logic pass; logic [7:0] byteV; int req; } expItem_t;
  expItem_t q[$];
  int compared = 0, mismatched = 0;
  logic m6 = 0, m2 = 0;
  bit finished = 0;

  function automatic int refSector(input logic [ADDR_W-1:0] a);
    if (a < 19'h04000) return 0;
    if (a < 19'h06000) return 1;
    if (a < 19'h08000) return 2;
    if (a < 19'h10000) return 3;
    return 3 + int'(a >> 16);
  endfunction

  task automatic startOp(input logic p, input logic e, input logic ce, input logic to);
    @(posedge clk); #1;
    opProgram = p; opErase = e; chipErase = ce; inTimeout = to; opStart = 1;
    m6 = 0; m2 = 0;
    @(posedge clk); #1;
    opStart = 0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input int req);
    expItem_t it;
    int s;
    logic busy, suspHit, hit2;
    @(posedge clk); #1;
    rdAddr = a; rdStrobe = 1;
    s = refSector(a);
    busy = opProgram || (!eraseSuspended && (opErase || inTimeout));
    suspHit = !opProgram && eraseSuspended && eraseSel[s];
    it.req = req;
    if (opProgram) begin
      it.pass = 0;
      it.byteV = {~progData[7], m6, timeLimit, 2'b00, m2, 2'b00};
      hit2 = eraseSuspended && eraseSel[s];
    end else if (suspHit) begin
      it.pass = 0;
      it.byteV = {1'b1, m6, 3'b000, m2, 2'b00};
      hit2 = 1;
    end else if (busy) begin
      it.pass = 0;
      it.byteV = {1'b0, m6, timeLimit, 1'b0, ~inTimeout, m2, 2'b00};
      hit2 = timeLimit ? failSel[s] : (chipErase || eraseSel[s]);
    end else begin
      it.pass = 1; it.byteV = 8'h00; hit2 = 0;
    end
    q.push_back(it);
    if (busy) m6 = ~m6;
    if (hit2) m2 = ~m2;
    @(posedge clk); #1;
    rdStrobe = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rdStrobe && q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      compared++;
      if (arrayPass !== e.pass || statusByte !== e.byteV) begin
        mismatched++;
        $display("FAIL R%0d: got pass=%b byte=%02h, expected pass=%b byte=%02h",
                 e.req, arrayPass, statusByte, e.pass, e.byteV);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset: array data, zero status
    doRead(19'h00000, 1);
    // R2 / R4 program, bit 7 inverted, busy toggle runs
    progData = 8'h5A;
    startOp(1, 0, 0, 0);
    doRead(19'h12345, 2); doRead(19'h12345, 4); doRead(19'h00010, 4);
    progData = 8'hC3;
    doRead(19'h12345, 2);
    // R6 time limit during program
    timeLimit = 1;
    doRead(19'h12345, 6); doRead(19'h12345, 6);
    timeLimit = 0;
    // R4 hold across array reads
    doRead(19'h12345, 4);
    opProgram = 0;
    doRead(19'h00000, 4); doRead(19'h00000, 4);
    opProgram = 1;
    doRead(19'h12345, 4);
    // R5 start clears toggles; R7/R3 erase window
    eraseSel = 11'b000_0001_0000;
    startOp(0, 0, 0, 1);
    doRead(19'h10000, 5);
    doRead(19'h10000, 7); doRead(19'h00100, 8); doRead(19'h1FFFF, 8);
    inTimeout = 0; opErase = 1;
    doRead(19'h10004, 7); doRead(19'h30000, 3);
    // R12 boundaries around sector 2
    eraseSel = 11'b000_0000_0100;
    startOp(0, 1, 0, 0);
    doRead(19'h05FFF, 12); doRead(19'h06000, 12); doRead(19'h07FFF, 12); doRead(19'h08000, 12);
    // R8 chip erase toggles everywhere
    eraseSel = '1;
    startOp(0, 1, 1, 0);
    doRead(19'h00000, 8); doRead(19'h7FFFF, 8); doRead(19'h44444, 8);
    // R9 time limit: only failed sectors
    eraseSel = 11'b000_0011_0000; failSel = 11'b000_0010_0000;
    startOp(0, 1, 0, 0);
    timeLimit = 1;
    doRead(19'h20000, 9); doRead(19'h10000, 9); doRead(19'h2FFFF, 9);
    timeLimit = 0; failSel = '0;
    // R10 suspended reads
    eraseSel = 11'b000_0001_0000;
    startOp(0, 1, 0, 0);
    doRead(19'h10000, 10);
    opErase = 0; eraseSuspended = 1;
    doRead(19'h10000, 10); doRead(19'h18000, 10); doRead(19'h50000, 10);
    // R11 program while suspended
    progData = 8'h80; opProgram = 1;
    doRead(19'h50000, 11); doRead(19'h10000, 11); doRead(19'h60000, 11);
    // R13 spare bits are covered by every expected byte above
    opProgram = 0; eraseSuspended = 0;
    doRead(19'h10000, 13);
    repeat (3) @(posedge clk);
    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL R1: %0d expected results never produced, expected 0", q.size());
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL R1: watchdog expired, got hang, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule